// File: doc/BRIEF.md
# Floating-Point Range Select Unit

This unit handles one single-precision lane. It takes two 32-bit operands and a 4-bit control word. It does no arithmetic. A comparison stage chooses one of the two operands by one of four orderings: minimum, maximum, minimum magnitude or maximum magnitude. A sign stage then rewrites bit 31 of the chosen word by one of four rules, and bits 30:0 pass through unchanged.

NaNs, signed zeros, equal-magnitude ties and subnormals all follow fixed rules. The unit reports two flags: invalid-operation and denormal-operand. When the flush input is set, subnormal fractions are cleared before the comparison. The unit is purely combinational, and its result and flags always reflect the inputs of the moment.

A typical use is bounding a value: the control word selects minimum magnitude, the second operand holds a limit L, and the sign of the first operand is kept. The result is then the input, clipped to the range from -L to +L.

Top module: `fprange_unit`

## Requirements
- R1: `ctrl[1:0]` selects the ordering: 00 minimum, 01 maximum, 10 minimum magnitude, 11 maximum magnitude. Minimum and maximum follow the IEEE value ordering. The magnitude modes compare bits 30:0.
- R2: `ctrl[3:2]` selects the sign of the result: 00 takes bit 31 of `op_a`, 01 keeps the sign of the chosen operand, 10 forces 0 and 11 forces 1. Bits 30:0 of the result always equal those of the chosen operand.
- R3: If `op_a` is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the result is `op_a` with bit 22 set. `flag_invalid` is 1, `flag_denormal` is 0, and the sign rule is not applied.
- R4: If `op_b` is a signalling NaN and `op_a` is not, the result is `op_b` with bit 22 set. `flag_invalid` is 1, `flag_denormal` is 0, and the sign rule is not applied.
- R5: If neither operand is a signalling NaN and `op_b` is a quiet NaN (fraction bit 22 set), `op_a` is chosen. Otherwise, if `op_a` is a quiet NaN, `op_b` is chosen. In both cases `flag_invalid` is 0 and the sign rule still applies.
- R6: For a +0 and a -0 operand in either order, minimum and minimum magnitude choose -0, and maximum and maximum magnitude choose +0.
- R7: For nonzero operands of equal magnitude and opposite sign, minimum magnitude chooses the negative operand and maximum magnitude chooses the positive one.
- R8: With `daz` = 0, `flag_denormal` is 1 when either operand has exponent 0 and a nonzero fraction, unless the other operand is a quiet NaN or a signalling NaN is present.
- R9: With `daz` = 1, a subnormal operand has its fraction cleared, keeping its sign, before the comparison and in the result. `flag_denormal` is then 0.
- R10: Control 0x2 with `op_b` = +L returns `op_a` when |`op_a`| < L. Otherwise it returns L carrying the sign of `op_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First single-precision operand; supplies the sign under rule 00 |
| op_b | input | 32 | Second single-precision operand |
| ctrl | input | 4 | [1:0] ordering select, [3:2] sign rule |
| daz | input | 1 | Flush subnormal operands to zero before comparing |
| result | output | 32 | Chosen operand after the sign rule, or a quieted signalling NaN |
| flag_invalid | output | 1 | A signalling NaN was present |
| flag_denormal | output | 1 | A subnormal operand was used unflushed |

## Verification
The bench targets the places where a range unit is easy to get slightly wrong:
- Signed-zero pairs in both operand orders. A plain value compare would return whichever zero came first.
- Equal-magnitude ties of opposite sign. Without the tie rule, the result would depend on operand order.
- Two signalling NaNs at once. A wrong priority returns the second one.
- A signalling NaN under the forced-sign rules. A design that applies the sign rule would flip the NaN's sign.
- A subnormal paired with a quiet NaN, where the flag must stay low.
- Flushed subnormals, which must tie like true zeros.
- The clamp pattern on both sides of the limit, which shows whether the first operand's sign survives the magnitude selection.

// File: rtl/fprange_pkg.sv
package fprange_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = WORD_W - 1;
    localparam int QBIT   = FRAC_W - 1;
    localparam int CTRL_W = 4;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [1:0] {
        CMP_MIN    = 2'b00,
        CMP_MAX    = 2'b01,
        CMP_MINMAG = 2'b10,
        CMP_MAXMAG = 2'b11
    } cmp_sel_e;

    typedef enum logic [1:0] {
        SGN_FIRST  = 2'b00,
        SGN_PICKED = 2'b01,
        SGN_PLUS   = 2'b10,
        SGN_MINUS  = 2'b11
    } sgn_sel_e;

    typedef struct packed {
        sgn_sel_e sgn;
        cmp_sel_e cmp;
    } range_ctrl_t;

    typedef struct packed {
        logic is_snan;
        logic is_qnan;
        logic is_zero;
        logic is_subn;
    } fp_class_t;

    function automatic fp_class_t classify(input fp_word_t w);
        fp_class_t c;
        logic exp_max;
        logic exp_min;
        logic frac_nz;
        exp_max   = &w.exp;
        exp_min   = ~|w.exp;
        frac_nz   = |w.frac;
        c.is_snan = exp_max && frac_nz && !w.frac[QBIT];
        c.is_qnan = exp_max && w.frac[QBIT];
        c.is_zero = exp_min && !frac_nz;
        c.is_subn = exp_min && frac_nz;
        return c;
    endfunction

    function automatic logic [MAG_W-1:0] magnitude(input fp_word_t w);
        return {w.exp, w.frac};
    endfunction

    function automatic fp_word_t quieten(input fp_word_t w);
        fp_word_t q;
        q = w;
        q.frac[QBIT] = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/fprange_prep.sv
module fprange_prep
    import fprange_pkg::*;
(
    input  fp_word_t  word_in,
    input  fp_word_t  other_in,
    input  logic      daz,
    output fp_class_t cls,
    output fp_word_t  word_out,
    output logic      subn_seen
);

    fp_class_t other_cls;

    always_comb begin
        cls       = classify(word_in);
        other_cls = classify(other_in);
        word_out  = word_in;
        if (cls.is_subn && daz) begin
            word_out.frac = '0;
        end
        subn_seen = cls.is_subn && !daz && !other_cls.is_qnan;
    end

    always_comb begin
        if (!$isunknown({word_in, daz})) begin
            a_r9_flush_gives_zero: assert (!(daz && cls.is_subn) ||
                                           (word_out.exp == '0 && word_out.frac == '0 &&
                                            word_out.sign == word_in.sign))
                else $error("flushed operand is not a signed zero");
        end
    end

endmodule

// File: rtl/fprange_pick.sv
module fprange_pick
    import fprange_pkg::*;
(
    input  fp_word_t  a_w,
    input  fp_word_t  b_w,
    input  fp_class_t a_cls,
    input  fp_class_t b_cls,
    input  cmp_sel_e  mode,
    output fp_word_t  picked
);

    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             mag_lt;
    logic             mag_eq;
    logic             val_lt;
    logic             min_like;

    always_comb begin
        mag_a    = magnitude(a_w);
        mag_b    = magnitude(b_w);
        mag_lt   = mag_a < mag_b;
        mag_eq   = mag_a == mag_b;
        min_like = (mode == CMP_MIN) || (mode == CMP_MINMAG);

        if (a_w.sign != b_w.sign) begin
            val_lt = a_w.sign;
        end else if (!a_w.sign) begin
            val_lt = mag_lt;
        end else begin
            val_lt = !mag_lt && !mag_eq;
        end

        if (b_cls.is_qnan) begin
            picked = a_w;
        end else if (a_cls.is_qnan) begin
            picked = b_w;
        end else if (mag_eq && (a_w.sign != b_w.sign)) begin
            picked = (a_w.sign == min_like) ? a_w : b_w;
        end else begin
            unique case (mode)
                CMP_MIN:    picked = val_lt ? a_w : b_w;
                CMP_MAX:    picked = val_lt ? b_w : a_w;
                CMP_MINMAG: picked = mag_lt ? a_w : b_w;
                default:    picked = mag_lt ? b_w : a_w;
            endcase
        end
    end

    always_comb begin
        if (!$isunknown({a_w, b_w, mode})) begin
            a_r1_pick_is_operand: assert (picked == a_w || picked == b_w)
                else $error("chosen word is neither operand");
            a_r1_minmag_not_larger: assert (mode != CMP_MINMAG || a_cls.is_qnan || b_cls.is_qnan ||
                                            magnitude(picked) <= mag_a && magnitude(picked) <= mag_b)
                else $error("minimum magnitude chose the larger operand");
            a_r7_tie_sign: assert (!(mag_eq && a_w.sign != b_w.sign && !a_cls.is_qnan &&
                                     !b_cls.is_qnan) || picked.sign == min_like)
                else $error("opposite-sign tie broken the wrong way");
        end
    end

endmodule

// File: rtl/fprange_sign.sv
module fprange_sign
    import fprange_pkg::*;
(
    input  fp_word_t picked,
    input  logic     first_sign,
    input  sgn_sel_e rule,
    output fp_word_t shaped
);

    always_comb begin
        shaped = picked;
        unique case (rule)
            SGN_FIRST:  shaped.sign = first_sign;
            SGN_PICKED: shaped.sign = picked.sign;
            SGN_PLUS:   shaped.sign = 1'b0;
            default:    shaped.sign = 1'b1;
        endcase
    end

endmodule

// File: rtl/fprange_unit.sv
module fprange_unit
    import fprange_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              daz,
    output logic [WORD_W-1:0] result,
    output logic              flag_invalid,
    output logic              flag_denormal
);

    localparam int N_OPS = 2;

    range_ctrl_t ctl;
    fp_word_t    raw_w   [N_OPS];
    fp_word_t    flush_w [N_OPS];
    fp_class_t   cls     [N_OPS];
    logic        subn_hit[N_OPS];
    fp_word_t    picked;
    fp_word_t    shaped;
    logic        snan_any;

    assign ctl      = range_ctrl_t'(ctrl);
    assign raw_w[0] = fp_word_t'(op_a);
    assign raw_w[1] = fp_word_t'(op_b);

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_prep
        fprange_prep u_prep (
            .word_in  (raw_w[gi]),
            .other_in (raw_w[N_OPS-1-gi]),
            .daz      (daz),
            .cls      (cls[gi]),
            .word_out (flush_w[gi]),
            .subn_seen(subn_hit[gi])
        );
    end

    fprange_pick u_pick (
        .a_w   (flush_w[0]),
        .b_w   (flush_w[1]),
        .a_cls (cls[0]),
        .b_cls (cls[1]),
        .mode  (ctl.cmp),
        .picked(picked)
    );

    fprange_sign u_sign (
        .picked    (picked),
        .first_sign(op_a[WORD_W-1]),
        .rule      (ctl.sgn),
        .shaped    (shaped)
    );

    always_comb begin
        snan_any      = cls[0].is_snan || cls[1].is_snan;
        flag_invalid  = snan_any;
        flag_denormal = !snan_any && (subn_hit[0] || subn_hit[1]);
        if (cls[0].is_snan) begin
            result = quieten(raw_w[0]);
        end else if (cls[1].is_snan) begin
            result = quieten(raw_w[1]);
        end else begin
            result = shaped;
        end
    end

    always_comb begin
        if (!$isunknown({op_a, op_b, ctrl, daz})) begin
            a_r3_invalid_is_quiet: assert (!flag_invalid ||
                                           (&result[WORD_W-2 -: EXP_W] && result[QBIT]))
                else $error("invalid raised without a quiet NaN result");
            a_r3_first_snan_wins: assert (!cls[0].is_snan || result == (op_a | (1 << QBIT)))
                else $error("first signalling NaN not returned");
            a_r2_low_bits_kept: assert (flag_invalid || result[MAG_W-1:0] == picked[MAG_W-1:0])
                else $error("sign stage altered bits below the sign");
            a_r8_flags_exclusive: assert (!(flag_invalid && flag_denormal))
                else $error("both flags raised");
            a_r9_daz_no_denormal: assert (!daz || !flag_denormal)
                else $error("denormal flag raised while flushing");
        end
    end

endmodule

// File: tb/fprange_unit_bench.sv
`timescale 1ns/1ps
module fprange_unit_bench;

    localparam int WATCHDOG_CYC = 10000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [3:0]  ctrl;
    logic        daz;
    logic [31:0] result;
    logic        flag_invalid;
    logic        flag_denormal;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] P1    = 32'h3F80_0000;
    localparam logic [31:0] N1    = 32'hBF80_0000;
    localparam logic [31:0] P2    = 32'h4000_0000;
    localparam logic [31:0] N2    = 32'hC000_0000;
    localparam logic [31:0] P100  = 32'h42C8_0000;
    localparam logic [31:0] N100  = 32'hC2C8_0000;
    localparam logic [31:0] P150  = 32'h4316_0000;
    localparam logic [31:0] N150  = 32'hC316_0000;
    localparam logic [31:0] P200  = 32'h4348_0000;
    localparam logic [31:0] N200  = 32'hC348_0000;
    localparam logic [31:0] PZ    = 32'h0000_0000;
    localparam logic [31:0] NZ    = 32'h8000_0000;
    localparam logic [31:0] QNAN  = 32'h7FC0_0000;
    localparam logic [31:0] PSUB  = 32'h0000_0001;
    localparam logic [31:0] NSUB  = 32'h8040_0000;

    always #5 clk = ~clk;

    fprange_unit u_fprange_unit (
        .op_a         (op_a),
        .op_b         (op_b),
        .ctrl         (ctrl),
        .daz          (daz),
        .result       (result),
        .flag_invalid (flag_invalid),
        .flag_denormal(flag_denormal)
    );

    task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] c, input logic z, input logic [31:0] exp_res,
                       input logic exp_inv, input logic exp_den);
        @(negedge clk);
        op_a = a;
        op_b = b;
        ctrl = c;
        daz  = z;
        #2;
        n_run++;
        if (result !== exp_res || flag_invalid !== exp_inv || flag_denormal !== exp_den) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h ctrl=%h daz=%b got res=%h inv=%b den=%b expected res=%h inv=%b den=%b",
                     tag, a, b, c, z, result, flag_invalid, flag_denormal, exp_res, exp_inv, exp_den);
        end
    endtask

    task automatic t_idle;
        run("R1 idle zeros", PZ, PZ, 4'h0, 1'b0, PZ, 1'b0, 1'b0);
    endtask

    task automatic t_orderings;
        run("R1 min mixed", P1, N2, 4'h4, 1'b0, N2, 1'b0, 1'b0);
        run("R1 max mixed", P1, N2, 4'h5, 1'b0, P1, 1'b0, 1'b0);
        run("R1 minmag mixed", P1, N2, 4'h6, 1'b0, P1, 1'b0, 1'b0);
        run("R1 maxmag mixed", P1, N2, 4'h7, 1'b0, N2, 1'b0, 1'b0);
        run("R1 min negatives", N1, N2, 4'h4, 1'b0, N2, 1'b0, 1'b0);
        run("R1 max negatives", N1, N2, 4'h5, 1'b0, N1, 1'b0, 1'b0);
        run("R1 max positives", P2, P1, 4'h5, 1'b0, P2, 1'b0, 1'b0);
    endtask

    task automatic t_sign_rules;
        run("R2 keep first sign", N1, P2, 4'h1, 1'b0, N2, 1'b0, 1'b0);
        run("R2 keep chosen sign", N1, P2, 4'h5, 1'b0, P2, 1'b0, 1'b0);
        run("R2 force plus", N1, N2, 4'h8, 1'b0, P2, 1'b0, 1'b0);
        run("R2 force minus", N1, P2, 4'hD, 1'b0, N2, 1'b0, 1'b0);
    endtask

    task automatic t_signalling;
        run("R3 first snan forced minus", 32'h7FA0_0000, P1, 4'hC, 1'b0, 32'h7FE0_0000, 1'b1, 1'b0);
        run("R3 both snan first wins", 32'h7F80_0005, 32'hFF80_0001, 4'h5, 1'b0, 32'h7FC0_0005, 1'b1, 1'b0);
        run("R4 second snan forced plus", P1, 32'hFF80_0001, 4'h8, 1'b0, 32'hFFC0_0001, 1'b1, 1'b0);
        run("R4 second snan with subnormal", PSUB, 32'h7F80_0010, 4'h4, 1'b0, 32'h7FC0_0010, 1'b1, 1'b0);
    endtask

    task automatic t_quiet;
        run("R5 second qnan picks first", P1, QNAN, 4'h4, 1'b0, P1, 1'b0, 1'b0);
        run("R5 first qnan picks second", 32'hFFC0_0000, P2, 4'h4, 1'b0, P2, 1'b0, 1'b0);
        run("R5 both qnan picks first", 32'h7FC0_0001, 32'hFFC0_0000, 4'h5, 1'b0, 32'h7FC0_0001, 1'b0, 1'b0);
        run("R5 sign rule still applies", P1, QNAN, 4'hF, 1'b0, N1, 1'b0, 1'b0);
    endtask

    task automatic t_zero_ties;
        run("R6 min +0,-0", PZ, NZ, 4'h4, 1'b0, NZ, 1'b0, 1'b0);
        run("R6 max +0,-0", PZ, NZ, 4'h5, 1'b0, PZ, 1'b0, 1'b0);
        run("R6 minmag +0,-0", PZ, NZ, 4'h6, 1'b0, NZ, 1'b0, 1'b0);
        run("R6 maxmag -0,+0", NZ, PZ, 4'h7, 1'b0, PZ, 1'b0, 1'b0);
        run("R6 max -0,+0", NZ, PZ, 4'h5, 1'b0, PZ, 1'b0, 1'b0);
        run("R6 min -0,+0", NZ, PZ, 4'h4, 1'b0, NZ, 1'b0, 1'b0);
    endtask

    task automatic t_mag_ties;
        run("R7 minmag +2,-2", P2, N2, 4'h6, 1'b0, N2, 1'b0, 1'b0);
        run("R7 maxmag +2,-2", P2, N2, 4'h7, 1'b0, P2, 1'b0, 1'b0);
        run("R7 minmag -2,+2", N2, P2, 4'h6, 1'b0, N2, 1'b0, 1'b0);
        run("R7 maxmag -2,+2", N2, P2, 4'h7, 1'b0, P2, 1'b0, 1'b0);
    endtask

    task automatic t_denormal;
        run("R8 first subnormal", PSUB, P1, 4'h4, 1'b0, PSUB, 1'b0, 1'b1);
        run("R8 second subnormal", P1, NSUB, 4'h4, 1'b0, NSUB, 1'b0, 1'b1);
        run("R8 subnormal beside qnan", PSUB, QNAN, 4'h4, 1'b0, PSUB, 1'b0, 1'b0);
        run("R8 qnan beside subnormal", QNAN, NSUB, 4'h4, 1'b0, NSUB, 1'b0, 1'b0);
    endtask

    task automatic t_flush;
        run("R9 flushed tie max", PSUB, NZ, 4'h5, 1'b1, PZ, 1'b0, 1'b0);
        run("R9 flushed tie min", PSUB, NZ, 4'h4, 1'b1, NZ, 1'b0, 1'b0);
        run("R9 flushed keeps sign", NSUB, P1, 4'h4, 1'b1, NZ, 1'b0, 1'b0);
    endtask

    task automatic t_clamp;
        run("R10 inside positive", P100, P150, 4'h2, 1'b0, P100, 1'b0, 1'b0);
        run("R10 inside negative", N100, P150, 4'h2, 1'b0, N100, 1'b0, 1'b0);
        run("R10 above limit", P200, P150, 4'h2, 1'b0, P150, 1'b0, 1'b0);
        run("R10 below limit", N200, P150, 4'h2, 1'b0, N150, 1'b0, 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst  = 1'b1;
        op_a = '0;
        op_b = '0;
        ctrl = '0;
        daz  = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_orderings();
        t_sign_rules();
        t_signalling();
        t_quiet();
        t_zero_ties();
        t_mag_ties();
        t_denormal();
        t_flush();
        t_clamp();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d checks expected completion", n_run);
            finish_run();
        end
    end

endmodule